// File: doc/BRIEF.md
# Cascaded Perceptron Pass/Fail Classifier

This block turns a vector of signed fixed-point measurements into a three-way test verdict: pass, fail or retest. It evaluates two small growing networks of hard-threshold perceptrons. One network draws the boundary that guards the nominal side and the other draws the boundary that guards the faulty side. Each network is a pyramid. Its first perceptron looks at a constant bias, the enabled measurements and one extra term, the sum of the squares of the enabled measurements. Every later perceptron sees the same inputs plus the ±1 decisions of all the perceptrons below it. Only the top active perceptron of each network gives that network's answer.

The weights come from offline training and are written one at a time through a write port. A configuration input sets how many layers take part, so a network can be trimmed back to the depth that generalised best. A mask input removes unwanted measurements. The start input launches an evaluation. The block runs one multiply-accumulate per clock through both networks and then pulses `done` for one cycle together with the two-bit verdict.

Top module: `cascade_classifier`

## Requirements
- R1: While reset is active and after it is released, `done` is 0 and `decision` is 2'b00 until the first evaluation completes.
- R2: Input slot NUM_FEAT+1 of every perceptron carries the parabolic term: the sum of the squares of the enabled features, shifted right by 8 so that it is in Q8.8 scale.
- R3: Slot 0 carries the constant 1.0 (256 in Q8.8). Slots 1..NUM_FEAT carry features 0..NUM_FEAT-1. Each product is feature (Q8.8) × weight (Q8.8), summed in Q16.16.
- R4: A perceptron outputs +1 (nominal) when its weighted sum is zero or positive, and -1 (faulty) when it is negative.
- R5: Perceptron l of a network also uses slots NUM_FEAT+2+j for j < l. These slots carry +1.0 or -1.0 according to the output of perceptron j of the same network.
- R6: `lastLayer` is the index of the output perceptron. Perceptrons above it are not evaluated and their weights have no effect on the verdict.
- R7: Bit k of `featMask` set to 0 makes feature k contribute zero, both to the weighted sums and to the parabolic term.
- R8: The verdict code is 2'b01 (pass) when both networks say nominal, 2'b10 (fail) when both say faulty, and 2'b11 (retest) when they disagree. It is held until the next completion.
- R9: The accumulator is 40-bit signed. It adds the slots in ascending order and saturates after every addition, so it never wraps.
- R10: `done` is a single-cycle pulse that appears exactly NUM_FEAT + 2·Σ_{l=0..lastLayer}(NUM_FEAT+2+l) clock edges after the edge that accepts `start`.
- R11: `start` is ignored while an evaluation is running. Features, mask and `lastLayer` are sampled on the accepting edge, and later changes have no effect on that evaluation.
- R12: `wrAddr` is {network, layer, slot}, with network 0 nominal and network 1 faulty, a 3-bit layer field and a 4-bit slot field. `wrData` is a signed Q8.8 weight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch an evaluation when idle |
| features | input | NUM_FEAT*16 | Packed signed Q8.8 measurements, feature 0 in the low bits |
| featMask | input | NUM_FEAT | Per-feature enable |
| lastLayer | input | 3 | Index of the output perceptron in both networks |
| wrEn | input | 1 | Weight write strobe |
| wrAddr | input | 8 | Weight address {network, layer, slot} |
| wrData | input | 16 | Signed Q8.8 weight |
| done | output | 1 | One-cycle completion pulse |
| decision | output | 2 | Verdict: 01 pass, 10 fail, 11 retest |

## Verification
The assertions assume that the weight port is quiet while an evaluation runs. They also assume that reset is applied before the first edge, and that `start` may arrive at any time, including during a run. The bench writes weights only between evaluations. It raises `start` in the middle of one run together with altered features, so the single-pulse and ignore-while-busy properties are exercised. The verdict and its exact arrival cycle are checked against a behavioural model that uses wide integers and clamps after every addition.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SQR  = 2'd1,
    ST_MAC  = 2'd2
  } cpc_state_t;

  typedef struct packed {
    logic capture;
    logic sqrEn;
    logic macEn;
    logic layerEnd;
    logic netEnd;
  } cpc_strobe_t;

  localparam logic [1:0] VERDICT_PASS   = 2'b01;
  localparam logic [1:0] VERDICT_FAIL   = 2'b10;
  localparam logic [1:0] VERDICT_RETEST = 2'b11;

endpackage

// File: rtl/cpc_weight_store.sv
module cpc_weight_store #(
  parameter int DATA_W     = 16,
  parameter int MAX_LAYERS = 8,
  parameter int SLOTS      = 13,
  parameter int LAYER_W    = 3,
  parameter int SLOT_W     = 4,
  parameter int ADDR_W     = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic signed [DATA_W-1:0] wrData,
  input  logic                     rdNet,
  input  logic [LAYER_W-1:0]       rdLayer,
  input  logic [SLOT_W-1:0]        rdSlot,
  output logic signed [DATA_W-1:0] rdData
);

  localparam int PER_NET = MAX_LAYERS * SLOTS;
  localparam int DEPTH   = 2 * PER_NET;

  logic signed [DATA_W-1:0] mem [DEPTH];

  logic               wNet;
  logic [LAYER_W-1:0] wLayer;
  logic [SLOT_W-1:0]  wSlot;
  int                 wIndex;
  int                 rIndex;
  logic               wLegal;

  assign wNet   = wrAddr[ADDR_W-1];
  assign wLayer = wrAddr[SLOT_W +: LAYER_W];
  assign wSlot  = wrAddr[SLOT_W-1:0];

  always_comb begin
    wIndex = int'(wNet) * PER_NET + int'(wLayer) * SLOTS + int'(wSlot);
    wLegal = (int'(wSlot) < SLOTS) && (int'(wLayer) < MAX_LAYERS);
    rIndex = int'(rdNet) * PER_NET + int'(rdLayer) * SLOTS + int'(rdSlot);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wrEn && wLegal) begin
      mem[wIndex] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (rIndex < DEPTH) rdData = mem[rIndex];
  end

endmodule

// File: rtl/cpc_control.sv
module cpc_control
  import cpc_pkg::*;
#(
  parameter int NUM_FEAT   = 4,
  parameter int MAX_LAYERS = 8,
  parameter int LAYER_W    = 3,
  parameter int SLOT_W     = 4,
  parameter int FIDX_W     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [LAYER_W-1:0] lastLayer,
  output cpc_strobe_t        strobe,
  output logic [FIDX_W-1:0]  featIdx,
  output logic [SLOT_W-1:0]  slotIdx,
  output logic [LAYER_W-1:0] layerIdx,
  output logic               netIdx,
  output logic               busy
);

  cpc_state_t         state;
  logic [LAYER_W-1:0] lastLayerReg;
  logic [SLOT_W-1:0]  lastSlot;
  logic               lastFeat;
  logic               slotWrap;
  logic               layerWrap;

  assign lastSlot  = SLOT_W'(NUM_FEAT + 1) + SLOT_W'(layerIdx);
  assign lastFeat  = (featIdx == FIDX_W'(NUM_FEAT - 1));
  assign slotWrap  = (slotIdx == lastSlot);
  assign layerWrap = (layerIdx == lastLayerReg);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strobe          = '0;
    strobe.capture  = (state == ST_IDLE) && start;
    strobe.sqrEn    = (state == ST_SQR);
    strobe.macEn    = (state == ST_MAC);
    strobe.layerEnd = (state == ST_MAC) && slotWrap;
    strobe.netEnd   = (state == ST_MAC) && slotWrap && layerWrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      featIdx      <= '0;
      slotIdx      <= '0;
      layerIdx     <= '0;
      netIdx       <= 1'b0;
      lastLayerReg <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state        <= ST_SQR;
            featIdx      <= '0;
            lastLayerReg <= lastLayer;
          end
        end
        ST_SQR: begin
          if (lastFeat) begin
            state    <= ST_MAC;
            slotIdx  <= '0;
            layerIdx <= '0;
            netIdx   <= 1'b0;
          end else begin
            featIdx <= featIdx + 1'b1;
          end
        end
        ST_MAC: begin
          if (slotWrap) begin
            slotIdx <= '0;
            if (layerWrap) begin
              layerIdx <= '0;
              if (netIdx) state <= ST_IDLE;
              else netIdx <= 1'b1;
            end else begin
              layerIdx <= layerIdx + 1'b1;
            end
          end else begin
            slotIdx <= slotIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cpc_datapath.sv
module cpc_datapath
  import cpc_pkg::*;
#(
  parameter int NUM_FEAT   = 4,
  parameter int DATA_W     = 16,
  parameter int FRAC_W     = 8,
  parameter int ACC_W      = 40,
  parameter int MAX_LAYERS = 8,
  parameter int LAYER_W    = 3,
  parameter int SLOT_W     = 4,
  parameter int FIDX_W     = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_FEAT*DATA_W-1:0] features,
  input  logic [NUM_FEAT-1:0]        featMask,
  input  cpc_strobe_t                strobe,
  input  logic [FIDX_W-1:0]          featIdx,
  input  logic [SLOT_W-1:0]          slotIdx,
  input  logic [LAYER_W-1:0]         layerIdx,
  input  logic                       netIdx,
  input  logic signed [DATA_W-1:0]   wtData,
  output logic                       done,
  output logic [1:0]                 decision
);

  localparam int PROD_W = ACC_W + DATA_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [ACC_W-1:0] ONE     = ACC_W'(1) << FRAC_W;
  localparam logic signed [ACC_W-1:0] NEG_ONE = -(ACC_W'(1) << FRAC_W);
  localparam logic signed [SUM_W-1:0] SAT_MAX =
    {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] SAT_MIN = ~SAT_MAX;

  logic [NUM_FEAT*DATA_W-1:0] featReg;
  logic [NUM_FEAT-1:0]        maskReg;
  logic signed [DATA_W-1:0]   featM [NUM_FEAT];
  logic signed [ACC_W-1:0]    sumSq;
  logic signed [ACC_W-1:0]    acc;
  logic [MAX_LAYERS-1:0]      outBits;
  logic                       nomBit;

  logic signed [ACC_W-1:0]  mulA;
  logic signed [DATA_W-1:0] mulB;
  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  sumFull;
  logic signed [ACC_W-1:0]  satSum;
  logic                     newBit;
  int                       sIdx;

  function automatic logic signed [ACC_W-1:0] widen(input logic signed [DATA_W-1:0] v);
    return {{(ACC_W-DATA_W){v[DATA_W-1]}}, v};
  endfunction

  for (genvar k = 0; k < NUM_FEAT; k++) begin : g_mask
    assign featM[k] = maskReg[k] ? featReg[k*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    mulA = '0;
    mulB = '0;
    sIdx = int'(slotIdx);
    if (strobe.sqrEn) begin
      mulA = widen(featM[int'(featIdx)]);
      mulB = featM[int'(featIdx)];
    end else if (strobe.macEn) begin
      mulB = wtData;
      if (sIdx == 0)                  mulA = ONE;
      else if (sIdx <= NUM_FEAT)      mulA = widen(featM[sIdx-1]);
      else if (sIdx == NUM_FEAT + 1)  mulA = sumSq >>> FRAC_W;
      else mulA = outBits[sIdx-NUM_FEAT-2] ? ONE : NEG_ONE;
    end
  end

  assign prod    = mulA * mulB;
  assign sumFull = {{(SUM_W-ACC_W){acc[ACC_W-1]}}, acc} + {prod[PROD_W-1], prod};

  always_comb begin
    if (sumFull > SAT_MAX)      satSum = SAT_MAX[ACC_W-1:0];
    else if (sumFull < SAT_MIN) satSum = SAT_MIN[ACC_W-1:0];
    else                        satSum = sumFull[ACC_W-1:0];
  end

  assign newBit = ~satSum[ACC_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      featReg  <= '0;
      maskReg  <= '0;
      sumSq    <= '0;
      acc      <= '0;
      outBits  <= '0;
      nomBit   <= 1'b0;
      done     <= 1'b0;
      decision <= 2'b00;
    end else begin
      done <= 1'b0;
      if (strobe.capture) begin
        featReg <= features;
        maskReg <= featMask;
        sumSq   <= '0;
        acc     <= '0;
      end
      if (strobe.sqrEn) sumSq <= sumSq + prod[ACC_W-1:0];
      if (strobe.macEn) begin
        if (strobe.layerEnd) begin
          outBits[layerIdx] <= newBit;
          acc               <= '0;
          if (strobe.netEnd) begin
            if (!netIdx) begin
              nomBit <= newBit;
            end else begin
              done <= 1'b1;
              if (nomBit && newBit)        decision <= VERDICT_PASS;
              else if (!nomBit && !newBit) decision <= VERDICT_FAIL;
              else                         decision <= VERDICT_RETEST;
            end
          end
        end else begin
          acc <= satSum;
        end
      end
    end
  end

endmodule

// File: rtl/cascade_classifier.sv
module cascade_classifier
  import cpc_pkg::*;
#(
  parameter int NUM_FEAT   = 4,
  parameter int DATA_W     = 16,
  parameter int FRAC_W     = 8,
  parameter int ACC_W      = 40,
  parameter int MAX_LAYERS = 8,
  localparam int SLOTS     = NUM_FEAT + 2 + MAX_LAYERS - 1,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int LAYER_W   = $clog2(MAX_LAYERS),
  localparam int ADDR_W    = 1 + LAYER_W + SLOT_W,
  localparam int FIDX_W    = $clog2(NUM_FEAT + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [NUM_FEAT*DATA_W-1:0] features,
  input  logic [NUM_FEAT-1:0]        featMask,
  input  logic [LAYER_W-1:0]         lastLayer,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  output logic                       done,
  output logic [1:0]                 decision
);

  cpc_strobe_t              strobe;
  logic [FIDX_W-1:0]        featIdx;
  logic [SLOT_W-1:0]        slotIdx;
  logic [LAYER_W-1:0]       layerIdx;
  logic                     netIdx;
  logic                     ctrlBusy;
  logic signed [DATA_W-1:0] wtData;

  cpc_weight_store #(
    .DATA_W(DATA_W), .MAX_LAYERS(MAX_LAYERS), .SLOTS(SLOTS),
    .LAYER_W(LAYER_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)
  ) store_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdNet(netIdx), .rdLayer(layerIdx),
    .rdSlot(slotIdx), .rdData(wtData)
  );

  cpc_control #(
    .NUM_FEAT(NUM_FEAT), .MAX_LAYERS(MAX_LAYERS), .LAYER_W(LAYER_W),
    .SLOT_W(SLOT_W), .FIDX_W(FIDX_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .lastLayer(lastLayer),
    .strobe(strobe), .featIdx(featIdx), .slotIdx(slotIdx),
    .layerIdx(layerIdx), .netIdx(netIdx), .busy(ctrlBusy)
  );

  cpc_datapath #(
    .NUM_FEAT(NUM_FEAT), .DATA_W(DATA_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W),
    .MAX_LAYERS(MAX_LAYERS), .LAYER_W(LAYER_W), .SLOT_W(SLOT_W),
    .FIDX_W(FIDX_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .features(features), .featMask(featMask),
    .strobe(strobe), .featIdx(featIdx), .slotIdx(slotIdx),
    .layerIdx(layerIdx), .netIdx(netIdx), .wtData(wtData),
    .done(done), .decision(decision)
  );

endmodule

// File: rtl/cpc_checker.sv
module cpc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] decision
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> (!done && decision == 2'b00));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

  // R10
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> $past(busy));

  // R8
  verdict_code_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> decision != 2'b00);

  // R8
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rstN) !done |-> $stable(decision));

  // R11
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN) (start && !busy) |=> busy);

endmodule

bind cascade_classifier cpc_checker chk_i (
  .clk(clk), .rstN(rstN), .start(start), .busy(ctrlBusy),
  .done(done), .decision(decision)
);

// File: tb/cascade_classifier_tb_top.sv
module cascade_classifier_tb_top;

  localparam int D      = 4;
  localparam int DW     = 16;
  localparam int LAYERS = 8;
  localparam int SLOTS  = 13;
  localparam longint SMAX = 64'sd549755813887;
  localparam longint SMIN = -64'sd549755813888;

  logic          clk = 1'b0;
  logic          rstN;
  logic          start;
  logic [D*DW-1:0] features;
  logic [D-1:0]  featMask;
  logic [2:0]    lastLayer;
  logic          wrEn;
  logic [7:0]    wrAddr;
  logic [15:0]   wrData;
  logic          done;
  logic [1:0]    decision;

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  int wts [2][LAYERS][SLOTS];
  int featV [D];
  int lcgState = 12345;

  always #2 clk = ~clk;

  cascade_classifier dut_i (
    .clk(clk), .rstN(rstN), .start(start), .features(features),
    .featMask(featMask), .lastLayer(lastLayer), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .done(done), .decision(decision)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run exceeded cycle limit, actual %0d expected <150000", cyc);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setFeat(input int a, input int b, input int c, input int e);
    featV[0] = a; featV[1] = b; featV[2] = c; featV[3] = e;
    for (int k = 0; k < D; k++) features[k*DW +: DW] = featV[k][15:0];
  endtask

  task automatic wr(input int n, input int l, input int s, input int v);
    @(posedge clk); #1;
    wrEn   = 1'b1;
    wrAddr = {n[0], l[2:0], s[3:0]};
    wrData = v[15:0];
    wts[n][l][s] = v;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic clearW();
    for (int n = 0; n < 2; n++)
      for (int l = 0; l < LAYERS; l++)
        for (int s = 0; s < SLOTS; s++)
          if (wts[n][l][s] != 0) wr(n, l, s, 0);
  endtask

  function automatic int nextRand(input int span);
    lcgState = lcgState * 1103515245 + 12345;
    return ((lcgState >>> 8) & 32'h7fff) % span;
  endfunction

  function automatic longint clampAdd(input longint a, input longint b);
    longint r;
    r = a + b;
    if (r > SMAX) r = SMAX;
    if (r < SMIN) r = SMIN;
    return r;
  endfunction

  function automatic logic [1:0] refVerdict();
    longint fm [D];
    longint sq;
    longint acc;
    longint op;
    bit outs [LAYERS];
    bit netRes [2];
    int last;
    last = int'(lastLayer);
    sq = 0;
    for (int k = 0; k < D; k++) begin
      fm[k] = featMask[k] ? longint'(featV[k]) : 0;
      sq += fm[k] * fm[k];
    end
    for (int n = 0; n < 2; n++) begin
      for (int l = 0; l <= last; l++) begin
        acc = 0;
        for (int s = 0; s <= D + 1 + l; s++) begin
          if (s == 0) op = 256;
          else if (s <= D) op = fm[s-1];
          else if (s == D + 1) op = sq >>> 8;
          else op = outs[s-D-2] ? 256 : -256;
          acc = clampAdd(acc, op * longint'(wts[n][l][s]));
        end
        outs[l] = (acc >= 0);
      end
      netRes[n] = outs[last];
    end
    if (netRes[0] && netRes[1]) return 2'b01;
    if (!netRes[0] && !netRes[1]) return 2'b10;
    return 2'b11;
  endfunction

  task automatic runEval(input string req, input int pokeAt);
    logic [1:0] expV;
    logic [1:0] got;
    int lat;
    int badCycle;
    expV = refVerdict();
    lat = D;
    for (int l = 0; l <= int'(lastLayer); l++) lat += 2 * (D + 2 + l);
    got = 2'b00;
    badCycle = -1;
    @(posedge clk); #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 1; k <= lat + 3; k++) begin
      if (k == pokeAt) begin
        start = 1'b1;
        features = ~features;
        featMask = ~featMask;
      end else begin
        start = 1'b0;
      end
      @(posedge clk); #1;
      if (done !== (k == lat) && badCycle < 0) badCycle = k;
      if (k == lat) got = decision;
    end
    start = 1'b0;
    if (pokeAt > 0) begin
      for (int k = 0; k < D; k++) features[k*DW +: DW] = featV[k][15:0];
      featMask = ~featMask;
    end
    check(badCycle < 0, {req, " R10 done timing (first bad cycle)"}, badCycle, -1);
    check(got == expV, {req, " verdict"}, int'(got), int'(expV));
  endtask

  initial begin
    for (int n = 0; n < 2; n++)
      for (int l = 0; l < LAYERS; l++)
        for (int s = 0; s < SLOTS; s++) wts[n][l][s] = 0;
    rstN = 1'b0; start = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    featMask = 4'b1111; lastLayer = 3'd0;
    setFeat(0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(decision == 2'b00, "R1 decision in reset", int'(decision), 0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(done == 1'b0 && decision == 2'b00, "R1 after release", int'(decision), 0);

    // R4: all-zero weights give zero sums, which count as nominal
    setFeat(300, -500, 77, 1000);
    runEval("R4 zero sum nominal", 0);

    // R8 / R12: bias-only boundaries on each network
    wr(0, 0, 0, -256);
    runEval("R8 retest nominal-net faulty", 0);
    wr(1, 0, 0, -256);
    runEval("R8 R12 fail both faulty", 0);
    wr(0, 0, 0, 256);
    runEval("R8 R12 retest faulty-net faulty", 0);
    clearW();

    // R3: feature 1 against a 1.5 threshold on both networks
    for (int n = 0; n < 2; n++) begin
      wr(n, 0, 0, -384);
      wr(n, 0, 2, 256);
    end
    setFeat(0, 512, 0, 0);
    runEval("R3 feature above threshold", 0);
    setFeat(0, 256, 0, 0);
    runEval("R3 feature below threshold", 0);
    clearW();

    // R2: parabolic term against radius squared 4.0
    for (int n = 0; n < 2; n++) begin
      wr(n, 0, 0, 1024);
      wr(n, 0, 5, -256);
    end
    setFeat(256, -256, 0, 0);
    runEval("R2 inside circle", 0);
    setFeat(512, 256, 0, 0);
    runEval("R2 outside circle", 0);
    setFeat(0, 0, -512, 0);
    runEval("R2 R4 on boundary", 0);

    // R7: masked feature drops out of the parabolic term
    setFeat(512, 256, 0, 0);
    featMask = 4'b1110;
    runEval("R7 masked feature", 0);
    featMask = 4'b1111;
    clearW();

    // R5 / R6: layer 1 inverts layer 0 on the nominal network
    wr(0, 0, 0, -256);
    wr(0, 1, 6, -256);
    setFeat(100, 100, 100, 100);
    lastLayer = 3'd0;
    runEval("R6 one layer", 0);
    lastLayer = 3'd1;
    runEval("R5 prior output used", 0);
    wr(0, 2, 0, -2048);
    runEval("R6 upper layer ignored", 0);
    lastLayer = 3'd2;
    runEval("R6 third layer active", 0);
    lastLayer = 3'd0;
    clearW();

    // R9: large terms overflow 40 bits unless clamped
    setFeat(32767, 32767, 32767, 32767);
    for (int s = 0; s <= D + 1; s++) wr(0, 0, s, 32767);
    runEval("R9 saturation keeps sign", 0);

    // R11: start and inputs changed mid-run are ignored
    runEval("R11 start while busy", 5);
    clearW();

    // mixed patterns with pseudo-random weights and features
    for (int t = 0; t < 6; t++) begin
      lastLayer = 3'(nextRand(4));
      featMask  = 4'(nextRand(16));
      setFeat(nextRand(2048) - 1024, nextRand(2048) - 1024,
              nextRand(2048) - 1024, nextRand(2048) - 1024);
      for (int n = 0; n < 2; n++)
        for (int l = 0; l <= int'(lastLayer); l++)
          for (int s = 0; s <= D + 1 + l; s++) wr(n, l, s, nextRand(1024) - 512);
      runEval("R3 R5 R7 mixed pattern", 0);
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule